// File: doc/BRIEF.md
# Handshake Strobe Delay Timer

This block times the programmable wait that a parallel port's strobe and pulse handshakes insert between their edges. An 8-bit delay setting carries a delay factor in its high nibble and a range code in its low nibble. The range code picks a base unit of time, and the factor counts how many units to wait. Time advances on a one-microsecond tick that a shared prescaler supplies.

A handshake controller presents its mode and the setting, then pulses `start`. The timer holds `busy` while it counts and gives a single-cycle `done` when the wait is over. How long it waits depends on the mode. Output strobe and output pulse wait factor times unit. Input strobe waits one unit less than that. The remaining input handshakes use no delay and answer at once. A new `start` always abandons the current count and begins again with the values present at that edge.

Top module: `strobe_delay_timer`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are both low.
- R2: The factor is `dly_cfg[7:4]` and the range code is `dly_cfg[3:0]`. Code 0000 gives 1000 ticks per unit, 0001 gives 1 tick, 0010 gives 10 ticks and 0011 gives 100 ticks. Every other code gives 1 tick.
- R3: In output strobe mode (`hs_mode` = 00) and output pulse mode (01), the wait is factor × unit ticks. Factor 1 gives one unit.
- R4: In input strobe mode (10), the wait is (factor − 1) × unit ticks.
- R5: When the effective wait is zero, `done` pulses in the cycle after `start` and `busy` stays low. This covers factor 0 in any of modes 00, 01 and 10, and factor 1 in mode 10.
- R6: In mode 11 (other input handshakes), the delay setting has no effect and `done` pulses in the cycle after `start`.
- R7: `done` lasts exactly one cycle, and `busy` falls in the same cycle that `done` rises.
- R8: A `start` while `busy` is high restarts the timer with the new setting and mode. The abandoned count produces no `done`.
- R9: A tick that is sampled on the same edge as `start` is not counted. `busy` stays high through the wait. `done` rises in the cycle after the edge that samples the last tick of the wait.
- R10: The setting and mode are captured at `start`. Changing them during a count does not alter that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse marking each microsecond |
| dly_cfg | input | 8 | Delay setting: factor in [7:4], range code in [3:0] |
| hs_mode | input | 2 | 00 output strobe, 01 output pulse, 10 input strobe, 11 other input |
| start | input | 1 | Begins or restarts a wait |
| busy | output | 1 | High while a wait is counting |
| done | output | 1 | One-cycle pulse when the wait ends |

## Verification
The bench counts the ticks between `start` and `done` for every range code and mode. This catches a design that uses the raw factor in input strobe mode, which would finish one unit late, and one that decodes the wrong unit, which would be off by a factor of ten or more. It aims at the zero-wait cases: factor 0, factor 1 in input strobe, and the other-input mode with a large setting. A design that starts counting in those cases would raise `busy` and hold back `done`. The bench scrambles the setting right after each start to expose a timer that reads it live rather than capturing it. It also restarts a long wait partway through, so a design that kept the old count would fire early or give two `done` pulses.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  typedef enum logic [1:0] {
    HS_OUT_STROBE = 2'b00,
    HS_OUT_PULSE  = 2'b01,
    HS_IN_STROBE  = 2'b10,
    HS_IN_OTHER   = 2'b11
  } hs_mode_e;
endpackage

// File: rtl/sdt_decode.sv
module sdt_decode #(
  parameter int FACT_W    = 4,
  parameter int CODE_W    = 4,
  parameter int UNIT_W    = 10,
  parameter int UNIT_SLOW = 1000,
  parameter int UNIT_FINE = 1,
  parameter int UNIT_MID  = 10,
  parameter int UNIT_WIDE = 100
) (
  input  logic [FACT_W+CODE_W-1:0] cfg,
  input  sdt_pkg::hs_mode_e        mode,
  output logic [FACT_W-1:0]        eff_factor,
  output logic [UNIT_W-1:0]        unit_ticks
);
  import sdt_pkg::*;

  logic [FACT_W-1:0] raw_factor;
  logic [CODE_W-1:0] code;

  assign raw_factor = cfg[FACT_W+CODE_W-1:CODE_W];
  assign code       = cfg[CODE_W-1:0];

  always_comb begin
    case (code)
      CODE_W'(0): unit_ticks = UNIT_W'(UNIT_SLOW);
      CODE_W'(1): unit_ticks = UNIT_W'(UNIT_FINE);
      CODE_W'(2): unit_ticks = UNIT_W'(UNIT_MID);
      CODE_W'(3): unit_ticks = UNIT_W'(UNIT_WIDE);
      default:    unit_ticks = UNIT_W'(UNIT_FINE);
    endcase
  end

  always_comb begin
    case (mode)
      HS_OUT_STROBE,
      HS_OUT_PULSE: eff_factor = raw_factor;
      HS_IN_STROBE: eff_factor = (raw_factor == '0) ? '0 : raw_factor - FACT_W'(1);
      default:      eff_factor = '0;
    endcase
  end
endmodule

// File: rtl/sdt_unit_timer.sv
module sdt_unit_timer #(
  parameter int UNIT_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [UNIT_W-1:0] unit_in,
  input  logic              run,
  input  logic              tick,
  output logic              unit_end
);
  logic [UNIT_W-1:0] unit_q;
  logic [UNIT_W-1:0] sub_cnt;

  assign unit_end = run && tick && !load && (sub_cnt == unit_q - UNIT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_q  <= UNIT_W'(1);
      sub_cnt <= '0;
    end else if (load) begin
      unit_q  <= (unit_in == '0) ? UNIT_W'(1) : unit_in;
      sub_cnt <= '0;
    end else if (run && tick) begin
      sub_cnt <= unit_end ? '0 : sub_cnt + UNIT_W'(1);
    end
  end

  // R2: sub-unit counter never reaches the latched unit length
  p_unit_bound_r2: assert property (@(posedge clk) disable iff (rst)
    sub_cnt < unit_q);
endmodule

// File: rtl/sdt_countdown.sv
module sdt_countdown #(
  parameter int FACT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FACT_W-1:0] eff_factor,
  input  logic              unit_end,
  output logic              busy,
  output logic              done
);
  logic [FACT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      remain <= eff_factor;
      busy   <= (eff_factor != '0);
      done   <= (eff_factor == '0);
    end else if (busy && unit_end) begin
      remain <= remain - FACT_W'(1);
      busy   <= (remain != FACT_W'(1));
      done   <= (remain == FACT_W'(1));
    end else begin
      done   <= 1'b0;
    end
  end

  // R3: a running count always has units left
  p_remain_live_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (remain != '0));
  // R7: done does not repeat without a new start
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);
  // R7: busy only falls when a done is issued
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

// File: rtl/strobe_delay_timer.sv
module strobe_delay_timer #(
  parameter int FACT_W    = 4,
  parameter int CODE_W    = 4,
  parameter int UNIT_SLOW = 1000,
  parameter int UNIT_FINE = 1,
  parameter int UNIT_MID  = 10,
  parameter int UNIT_WIDE = 100
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick_us,
  input  logic [FACT_W+CODE_W-1:0] dly_cfg,
  input  logic [1:0]               hs_mode,
  input  logic                     start,
  output logic                     busy,
  output logic                     done
);
  import sdt_pkg::*;

  localparam int UNIT_MAX = (UNIT_SLOW > UNIT_WIDE) ? UNIT_SLOW : UNIT_WIDE;
  localparam int UNIT_W   = $clog2(UNIT_MAX + 1);

  logic [FACT_W-1:0] eff_factor;
  logic [UNIT_W-1:0] unit_ticks;
  logic              unit_end;

  sdt_decode #(
    .FACT_W(FACT_W), .CODE_W(CODE_W), .UNIT_W(UNIT_W),
    .UNIT_SLOW(UNIT_SLOW), .UNIT_FINE(UNIT_FINE),
    .UNIT_MID(UNIT_MID), .UNIT_WIDE(UNIT_WIDE)
  ) u_decode (
    .cfg        (dly_cfg),
    .mode       (hs_mode_e'(hs_mode)),
    .eff_factor (eff_factor),
    .unit_ticks (unit_ticks)
  );

  sdt_unit_timer #(.UNIT_W(UNIT_W)) u_unit (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .unit_in  (unit_ticks),
    .run      (busy),
    .tick     (tick_us),
    .unit_end (unit_end)
  );

  sdt_countdown #(.FACT_W(FACT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .eff_factor (eff_factor),
    .unit_end   (unit_end),
    .busy       (busy),
    .done       (done)
  );

  // R6: other-input mode answers on the next cycle without counting
  p_other_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (start && hs_mode == 2'b11) |=> (done && !busy));
  // R9: counting and completion never overlap
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R1: outputs idle in the cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done));
endmodule

// File: tb/strobe_delay_timer_bench.sv
module strobe_delay_timer_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  TICK_DIV   = 3;
  localparam int  WAIT_LIMIT = 60000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_us = 1'b0;
  logic [7:0] dly_cfg = 8'h00;
  logic [1:0] hs_mode = 2'b00;
  logic       start = 1'b0;
  logic       busy, done;

  int checks = 0;
  int fails  = 0;
  int tdiv   = 0;

  strobe_delay_timer u_strobe_delay_timer (
    .clk(clk), .rst(rst), .tick_us(tick_us), .dly_cfg(dly_cfg),
    .hs_mode(hs_mode), .start(start), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick_us <= (tdiv == TICK_DIV - 1);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue a start at a negedge; afterwards scramble inputs (R10)
  task automatic issue(input logic [1:0] m, input logic [7:0] c);
    @(negedge clk);
    hs_mode = m; dly_cfg = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0; dly_cfg = ~c; hs_mode = ~m;
  endtask

  // Count ticks sampled until done; report busy-low while waiting
  task automatic wait_done(input int max_ticks, output int n, output int busy_gaps,
                           output bit seen);
    bit t;
    n = 0; busy_gaps = 0; seen = 0;
    for (int i = 0; i < WAIT_LIMIT; i++) begin
      if (done) begin seen = 1; break; end
      if (!busy) busy_gaps++;
      if (n >= max_ticks) break;
      @(posedge clk); t = tick_us;
      @(negedge clk); if (t) n++;
    end
  endtask

  task automatic run_case(input string req, input logic [1:0] m,
                          input logic [7:0] c, input int exp_ticks);
    int n, gaps; bit seen;
    issue(m, c);
    wait_done(exp_ticks + 5, n, gaps, seen);
    check({req, " done seen"}, seen, 1);
    check({req, " tick count"}, n, exp_ticks);
    check({req, " busy held"}, gaps, 0);
    if (exp_ticks == 0) check({req, " busy low on zero wait"}, busy, 0);
    @(negedge clk);
    check({req, " R7 done width"}, done, 0);
    check({req, " R7 busy after"}, busy, 0);
  endtask

  task automatic test_reset;
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
  endtask

  task automatic test_restart;
    int n, gaps; bit seen;
    issue(2'b01, 8'h52);
    wait_done(20, n, gaps, seen);
    check("R8 no early done", seen, 0);
    check("R8 first leg busy", busy, 1);
    run_case("R8 restart", 2'b00, 8'h22, 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_case("R3 out strobe f2 u1", 2'b00, 8'h21, 2);
    run_case("R3 out pulse f15 u10", 2'b01, 8'hF2, 150);
    run_case("R3 R2 out strobe f5 u100", 2'b00, 8'h53, 500);
    run_case("R3 out f1 u10", 2'b01, 8'h12, 10);
    run_case("R4 R2 in strobe 1ms", 2'b10, 8'h20, 1000);
    run_case("R4 in strobe f15 u10", 2'b10, 8'hF2, 140);
    run_case("R2 unused code", 2'b00, 8'h37, 3);
    run_case("R5 factor zero", 2'b00, 8'h03, 0);
    run_case("R5 in strobe f1", 2'b10, 8'h10, 0);
    run_case("R6 other input", 2'b11, 8'hF0, 0);
    run_case("R9 R10 scrambled inputs", 2'b10, 8'h43, 300);
    test_restart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule